// File: doc/BRIEF.md
# System Instruction CSR Execution Unit

This unit carries out the system-class instructions of a 64-bit integer pipeline. It holds a small bank of control/status registers and performs three read-modify-write operations on them: replace, set bits and clear bits. Each operation comes in two forms. The register form takes its source from operand 1. The immediate form takes a 5-bit field and zero-extends it. The same instruction class also carries three trap-raising instructions: environment call, breakpoint and exception return. These are selected by the 12-bit field when funct3 is zero.

The pipeline presents one instruction per cycle with `in_valid` high. The old register value and the illegal flag are driven combinationally in that same cycle. Any register update commits on the next rising clock edge. A trap instruction moves a small state machine out of `TS_IDLE` into `TS_ECALL`, `TS_EBREAK` or `TS_XRET`. That state lasts exactly one cycle and drives the matching trap request. The next state is always taken from the instruction presented in the current cycle: `TS_IDLE` when no trap instruction is valid, otherwise the state for that trap. A trap instruction can therefore move any state to any trap state.

The four implemented registers are at addresses 0x340, 0x341, 0x305 and 0x7C0. They are indices 0 to 3 and all reset to zero.

Top module: `sysop_csr_unit`

## Requirements
- R1: For a valid instruction with funct3 1, 2, 3, 5, 6 or 7 and a mapped address, `rd_value` shows the register's value as it was before the instruction, in the same cycle.
- R2: funct3 1 stores operand 1 and funct3 5 stores the 5-bit immediate zero-extended. The store lands on the next rising edge.
- R3: funct3 2 and 6 store old OR source, but only when the source is nonzero. With a zero source the register is unchanged.
- R4: funct3 3 and 7 store old AND NOT source, but only when the source is nonzero. With a zero source the register is unchanged.
- R5: funct3 1 and 5 store their source even when it is zero.
- R6: A register-access instruction to an address other than 0x340, 0x341, 0x305 or 0x7C0 raises `illegal` in the same cycle. It changes no register and returns zero on `rd_value`.
- R7: funct3 4 raises `illegal` and returns zero. It changes no register and requests no trap.
- R8: funct3 0 with field 0x000, 0x001 or 0x100 gives a one-cycle pulse on `trap_ecall`, `trap_ebreak` or `trap_xret` respectively, in the cycle after it is presented. It causes no register write, does not raise `illegal`, and returns zero.
- R9: funct3 0 with any other field value raises `illegal` and requests no trap.
- R10: After reset all four registers read zero and all trap requests are low. At most one trap request is high in any cycle.
- R11: While `in_valid` is low, no register changes, `illegal` is low, `rd_value` is zero and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_funct3 | input | 3 | Operation selector |
| in_field12 | input | 12 | Register address, or trap selector when funct3 is 0 |
| in_opnd1 | input | 64 | Source value for the register forms |
| in_uimm | input | 5 | Source value for the immediate forms, zero-extended |
| rd_value | output | 64 | Prior register value for the destination |
| illegal | output | 1 | Instruction cannot be executed |
| trap_ecall | output | 1 | Environment call request pulse |
| trap_ebreak | output | 1 | Breakpoint request pulse |
| trap_xret | output | 1 | Exception return request pulse |

## Verification
The assertions assume the inputs are known whenever `in_valid` is high, and that `in_valid` is held low while reset is applied. The bench drives all inputs only on falling edges and keeps `in_valid` low during and just after reset. Between instructions it returns `in_valid` to low, so every trap pulse can be seen to rise and then fall. Register contents are read back only through a set-immediate instruction with a zero immediate, which by R3 cannot change the register it reads.

// File: rtl/sysop_csr_pkg.sv
package sysop_csr_pkg;

    localparam int XLEN      = 64;
    localparam int ADDR_W    = 12;
    localparam int UIMM_W    = 5;
    localparam int NUM_REGS  = 4;
    localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REGS] = '{
        12'h340, 12'h341, 12'h305, 12'h7C0
    };

    localparam logic [ADDR_W-1:0] SEL_ECALL  = 12'h000;
    localparam logic [ADDR_W-1:0] SEL_EBREAK = 12'h001;
    localparam logic [ADDR_W-1:0] SEL_XRET   = 12'h100;

    typedef enum logic [2:0] {
        F3_SYS   = 3'd0,
        F3_RW    = 3'd1,
        F3_RS    = 3'd2,
        F3_RC    = 3'd3,
        F3_RSV   = 3'd4,
        F3_RWI   = 3'd5,
        F3_RSI   = 3'd6,
        F3_RCI   = 3'd7
    } funct3_e;

    typedef enum logic [1:0] {
        UPD_WRITE = 2'd0,
        UPD_SET   = 2'd1,
        UPD_CLEAR = 2'd2
    } upd_e;

    typedef enum logic [1:0] {
        TRQ_NONE   = 2'd0,
        TRQ_ECALL  = 2'd1,
        TRQ_EBREAK = 2'd2,
        TRQ_XRET   = 2'd3
    } trap_req_e;

    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,
        TS_ECALL  = 2'd1,
        TS_EBREAK = 2'd2,
        TS_XRET   = 2'd3
    } trap_state_e;

endpackage

// File: rtl/sysop_decode.sv
module sysop_decode
    import sysop_csr_pkg::*;
(
    input  logic              valid,
    input  logic [2:0]        funct3,
    input  logic [ADDR_W-1:0] field12,
    input  logic [XLEN-1:0]   opnd1,
    input  logic [UIMM_W-1:0] uimm,
    output logic              is_reg_op,
    output upd_e              upd_kind,
    output logic [XLEN-1:0]   src_value,
    output trap_req_e         trap_req,
    output logic              bad_op
);

    funct3_e f3;
    assign f3 = funct3_e'(funct3);

    always_comb begin
        is_reg_op = 1'b0;
        upd_kind  = UPD_WRITE;
        src_value = opnd1;
        trap_req  = TRQ_NONE;
        bad_op    = 1'b0;
        if (valid) begin
            unique case (f3)
                F3_SYS: begin
                    unique case (field12)
                        SEL_ECALL:  trap_req = TRQ_ECALL;
                        SEL_EBREAK: trap_req = TRQ_EBREAK;
                        SEL_XRET:   trap_req = TRQ_XRET;
                        default:    bad_op   = 1'b1;
                    endcase
                end
                F3_RW: begin
                    is_reg_op = 1'b1;
                    upd_kind  = UPD_WRITE;
                end
                F3_RS: begin
                    is_reg_op = 1'b1;
                    upd_kind  = UPD_SET;
                end
                F3_RC: begin
                    is_reg_op = 1'b1;
                    upd_kind  = UPD_CLEAR;
                end
                F3_RSV: begin
                    bad_op = 1'b1;
                end
                F3_RWI: begin
                    is_reg_op = 1'b1;
                    upd_kind  = UPD_WRITE;
                    src_value = {{(XLEN-UIMM_W){1'b0}}, uimm};
                end
                F3_RSI: begin
                    is_reg_op = 1'b1;
                    upd_kind  = UPD_SET;
                    src_value = {{(XLEN-UIMM_W){1'b0}}, uimm};
                end
                F3_RCI: begin
                    is_reg_op = 1'b1;
                    upd_kind  = UPD_CLEAR;
                    src_value = {{(XLEN-UIMM_W){1'b0}}, uimm};
                end
            endcase
        end
    end

endmodule

// File: rtl/sysop_reg_bank.sv
module sysop_reg_bank
    import sysop_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  upd_e              upd_kind,
    input  logic [XLEN-1:0]   src_value,
    output logic              hit,
    output logic [XLEN-1:0]   old_value,
    output logic              wr_fire
);

    logic [NUM_REGS-1:0] match;
    logic [XLEN-1:0]     regs [NUM_REGS];
    logic [IDX_W-1:0]    sel_idx;
    logic [XLEN-1:0]     new_value;
    logic                src_nonzero;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_match
        assign match[g] = (addr == REG_ADDR[g]);
    end

    always_comb begin
        sel_idx = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (match[i]) sel_idx = IDX_W'(i);
        end
    end

    assign hit         = |match;
    assign old_value   = regs[sel_idx];
    assign src_nonzero = |src_value;

    always_comb begin
        unique case (upd_kind)
            UPD_WRITE: new_value = src_value;
            UPD_SET:   new_value = old_value | src_value;
            UPD_CLEAR: new_value = old_value & ~src_value;
            default:   new_value = old_value;
        endcase
    end

    assign wr_fire = req && hit && ((upd_kind == UPD_WRITE) || src_nonzero);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_fire && match[g]) begin
                regs[g] <= new_value;
            end
        end
    end

endmodule

// File: rtl/sysop_trap_fsm.sv
module sysop_trap_fsm
    import sysop_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trap_req_e trap_req,
    output logic      pulse_ecall,
    output logic      pulse_ebreak,
    output logic      pulse_xret
);

    trap_state_e state_q, state_d;

    always_comb begin
        unique case (trap_req)
            TRQ_NONE:   state_d = TS_IDLE;
            TRQ_ECALL:  state_d = TS_ECALL;
            TRQ_EBREAK: state_d = TS_EBREAK;
            TRQ_XRET:   state_d = TS_XRET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_ecall  = 1'b0;
        pulse_ebreak = 1'b0;
        pulse_xret   = 1'b0;
        unique case (state_q)
            TS_IDLE:   ;
            TS_ECALL:  pulse_ecall  = 1'b1;
            TS_EBREAK: pulse_ebreak = 1'b1;
            TS_XRET:   pulse_xret   = 1'b1;
        endcase
    end

endmodule

// File: rtl/sysop_csr_unit.sv
module sysop_csr_unit
    import sysop_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_funct3,
    input  logic [ADDR_W-1:0] in_field12,
    input  logic [XLEN-1:0]   in_opnd1,
    input  logic [UIMM_W-1:0] in_uimm,
    output logic [XLEN-1:0]   rd_value,
    output logic              illegal,
    output logic              trap_ecall,
    output logic              trap_ebreak,
    output logic              trap_xret
);

    logic            is_reg_op;
    upd_e            upd_kind;
    logic [XLEN-1:0] src_value;
    trap_req_e       trap_req;
    logic            bad_op;
    logic            hit;
    logic [XLEN-1:0] old_value;
    logic            wr_fire;

    sysop_decode u_decode (
        .valid     (in_valid),
        .funct3    (in_funct3),
        .field12   (in_field12),
        .opnd1     (in_opnd1),
        .uimm      (in_uimm),
        .is_reg_op (is_reg_op),
        .upd_kind  (upd_kind),
        .src_value (src_value),
        .trap_req  (trap_req),
        .bad_op    (bad_op)
    );

    sysop_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (is_reg_op),
        .addr      (in_field12),
        .upd_kind  (upd_kind),
        .src_value (src_value),
        .hit       (hit),
        .old_value (old_value),
        .wr_fire   (wr_fire)
    );

    sysop_trap_fsm u_trap (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_req     (trap_req),
        .pulse_ecall  (trap_ecall),
        .pulse_ebreak (trap_ebreak),
        .pulse_xret   (trap_xret)
    );

    assign illegal  = bad_op || (is_reg_op && !hit);
    assign rd_value = (is_reg_op && hit) ? old_value : '0;

endmodule

// File: rtl/sysop_csr_checker.sv
module sysop_csr_checker
    import sysop_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_funct3,
    input logic [ADDR_W-1:0] in_field12,
    input logic [XLEN-1:0]   in_opnd1,
    input logic [UIMM_W-1:0] in_uimm,
    input logic [XLEN-1:0]   rd_value,
    input logic              illegal,
    input logic              trap_ecall,
    input logic              trap_ebreak,
    input logic              trap_xret,
    input logic              wr_fire
);

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_fire); // R6

    AST_RSV_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_funct3 == 3'd4) |-> (illegal && rd_value == '0)); // R7

    AST_SET_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_funct3 == 3'd6 && in_uimm == '0) |-> !wr_fire); // R3

    AST_CLR_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_funct3 == 3'd3 && in_opnd1 == '0) |-> !wr_fire); // R4

    AST_ECALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_funct3 == 3'd0 && in_field12 == SEL_ECALL) |=> trap_ecall); // R8

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_funct3 == 3'd0) |-> !wr_fire); // R8

    AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_ecall, trap_ebreak, trap_xret})); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!illegal && !wr_fire && rd_value == '0)); // R11

    AST_IDLE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(trap_ecall || trap_ebreak || trap_xret)); // R11

endmodule

bind sysop_csr_unit sysop_csr_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_funct3  (in_funct3),
    .in_field12 (in_field12),
    .in_opnd1   (in_opnd1),
    .in_uimm    (in_uimm),
    .rd_value   (rd_value),
    .illegal    (illegal),
    .trap_ecall (trap_ecall),
    .trap_ebreak(trap_ebreak),
    .trap_xret  (trap_xret),
    .wr_fire    (wr_fire)
);

// File: tb/sysop_csr_unit_tb.sv
module sysop_csr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_funct3 = '0;
    logic [11:0] in_field12 = '0;
    logic [63:0] in_opnd1 = '0;
    logic [4:0]  in_uimm = '0;
    logic [63:0] rd_value;
    logic        illegal;
    logic        trap_ecall, trap_ebreak, trap_xret;

    int total = 0;
    int bad = 0;

    logic [63:0] model [4];
    logic [11:0] addrs [4] = '{12'h340, 12'h341, 12'h305, 12'h7C0};

    always #10 clk = ~clk;

    sysop_csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_funct3(in_funct3),
        .in_field12(in_field12), .in_opnd1(in_opnd1), .in_uimm(in_uimm),
        .rd_value(rd_value), .illegal(illegal), .trap_ecall(trap_ecall),
        .trap_ebreak(trap_ebreak), .trap_xret(trap_xret)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Presents one instruction for one cycle; returns comb results, then idles.
    task automatic issue(input logic [2:0] f3, input logic [11:0] fld,
                         input logic [63:0] op1, input logic [4:0] imm,
                         output logic [63:0] rv, output logic ill,
                         output logic [2:0] traps);
        @(negedge clk);
        in_valid = 1'b1; in_funct3 = f3; in_field12 = fld; in_opnd1 = op1; in_uimm = imm;
        #5;
        rv = rd_value; ill = illegal;
        @(negedge clk);
        in_valid = 1'b0; in_opnd1 = '0; in_uimm = '0;
        traps = {trap_ecall, trap_ebreak, trap_xret};
    endtask

    task automatic read_reg(input int i, input string req);
        logic [63:0] rv; logic ill; logic [2:0] tr;
        issue(3'd6, addrs[i], 64'h0, 5'd0, rv, ill, tr);
        check(req, rv, model[i]);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) read_reg(i, "R10");
        check("R10", {61'd0, trap_ecall, trap_ebreak, trap_xret}, 64'd0);
    endtask

    task automatic t_write();
        logic [63:0] rv; logic ill; logic [2:0] tr;
        issue(3'd1, addrs[0], 64'hDEAD_BEEF_0123_4567, 5'd0, rv, ill, tr);
        check("R1", rv, 64'd0);
        model[0] = 64'hDEAD_BEEF_0123_4567;
        read_reg(0, "R2");
        issue(3'd5, addrs[1], 64'hFFFF_FFFF_FFFF_FFFF, 5'h1F, rv, ill, tr);
        model[1] = 64'h1F;
        read_reg(1, "R2");
        issue(3'd1, addrs[0], 64'h0, 5'd0, rv, ill, tr);
        check("R1", rv, 64'hDEAD_BEEF_0123_4567);
        model[0] = 64'h0;
        read_reg(0, "R5");
        issue(3'd5, addrs[1], 64'h55, 5'd0, rv, ill, tr);
        model[1] = 64'h0;
        read_reg(1, "R5");
    endtask

    task automatic t_set_clear();
        logic [63:0] rv; logic ill; logic [2:0] tr;
        issue(3'd1, addrs[2], 64'hF0F0_0000_0000_00F0, 5'd0, rv, ill, tr);
        model[2] = 64'hF0F0_0000_0000_00F0;
        issue(3'd2, addrs[2], 64'h0000_0000_0000_000F, 5'd0, rv, ill, tr);
        check("R1", rv, 64'hF0F0_0000_0000_00F0);
        model[2] = model[2] | 64'hF;
        read_reg(2, "R3");
        issue(3'd2, addrs[2], 64'h0, 5'd0, rv, ill, tr);
        read_reg(2, "R3");
        issue(3'd3, addrs[2], 64'hF000_0000_0000_0003, 5'd0, rv, ill, tr);
        model[2] = model[2] & ~64'hF000_0000_0000_0003;
        read_reg(2, "R4");
        issue(3'd7, addrs[2], 64'h0, 5'h0C, rv, ill, tr);
        model[2] = model[2] & ~64'hC;
        read_reg(2, "R4");
        issue(3'd7, addrs[2], 64'hFFFF, 5'd0, rv, ill, tr);
        read_reg(2, "R4");
        issue(3'd6, addrs[3], 64'h0, 5'h11, rv, ill, tr);
        model[3] = 64'h11;
        read_reg(3, "R3");
    endtask

    task automatic t_illegal();
        logic [63:0] rv; logic ill; logic [2:0] tr;
        issue(3'd1, 12'h342, 64'h1234, 5'd0, rv, ill, tr);
        check("R6", {63'd0, ill}, 64'd1);
        check("R6", rv, 64'd0);
        for (int i = 0; i < 4; i++) read_reg(i, "R6");
        issue(3'd4, addrs[0], 64'hABCD, 5'h3, rv, ill, tr);
        check("R7", {63'd0, ill}, 64'd1);
        check("R7", rv, 64'd0);
        check("R7", {61'd0, tr}, 64'd0);
        read_reg(0, "R7");
        issue(3'd0, 12'h002, 64'h0, 5'd0, rv, ill, tr);
        check("R9", {63'd0, ill}, 64'd1);
        check("R9", {61'd0, tr}, 64'd0);
    endtask

    task automatic t_traps();
        logic [63:0] rv; logic ill; logic [2:0] tr;
        logic [11:0] sel [3] = '{12'h000, 12'h001, 12'h100};
        logic [2:0]  exp [3] = '{3'b100, 3'b010, 3'b001};
        for (int k = 0; k < 3; k++) begin
            issue(3'd0, sel[k], 64'h0, 5'd0, rv, ill, tr);
            check("R8", {61'd0, tr}, {61'd0, exp[k]});
            check("R8", {63'd0, ill}, 64'd0);
            check("R8", rv, 64'd0);
            @(negedge clk);
            check("R8", {61'd0, trap_ecall, trap_ebreak, trap_xret}, 64'd0);
        end
        for (int i = 0; i < 4; i++) read_reg(i, "R8");
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_funct3 = 3'd1; in_field12 = addrs[3]; in_opnd1 = 64'hFFFF;
        #5;
        check("R11", rd_value, 64'd0);
        check("R11", {63'd0, illegal}, 64'd0);
        @(negedge clk);
        check("R11", {61'd0, trap_ecall, trap_ebreak, trap_xret}, 64'd0);
        in_opnd1 = '0;
        read_reg(3, "R11");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_set_clear();
        t_illegal();
        t_traps();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule